// File: doc/BRIEF.md
# Command-Channel Register File

This block is a small bank of storage registers served by a single command channel. Each command word holds three things: a mode bit that chooses read or write, a register address and a data word. A write stores its data and finishes at once. Nothing appears on the response channel for a write. A read returns the addressed register, zero-extended, on a separate response channel. Both channels use valid/ready handshakes.

Only one command is in flight at a time. A read command is held unacknowledged until its response has been taken downstream. A synchronous active-high reset clears every register. All stored bits are also driven out as a flat observation vector, with the lowest address in the lowest bits. The defaults give four 2-bit registers, a 5-bit command word and a 4-bit response.

Top module: `cmdreg_file`

## Requirements
- R1: The command word has the mode in bit 4, where 0 means write and 1 means read. The address is in bits 3:2 and the write data is in bits 1:0.
- R2: A write updates the addressed register on the clock edge where cmd_valid and cmd_ready are both high. Register a then shows on obs bits 2a+1:2a from the next cycle on.
- R3: While no read is pending, cmd_ready is high whenever the presented word is a write. An accepted write never raises rsp_valid.
- R4: A read presented while the block is idle raises rsp_valid one cycle later. rsp_data then carries the addressed register's value, zero-extended to 4 bits.
- R5: A read is not acknowledged before its response is taken. While a response is pending, cmd_ready equals rsp_ready. The read command and its response therefore complete on the same edge, and rsp_valid is low in the next cycle.
- R6: While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_data hold steady.
- R7: A read leaves every register unchanged, and the data bits of a read command have no effect.
- R8: Synchronous reset clears all registers and obs to 0, drops rsp_valid and clears rsp_data.
- R9: rsp_data reads 0 whenever rsp_valid is low.
- R10: With cmd_valid low, no register changes and no response starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command word accepted on this edge |
| cmd_word | input | 5 | Mode, address and data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_data | output | 4 | Zero-extended register value |
| obs | output | 8 | All registers, address 0 in the low bits |

## Verification
A write shows on obs at the first edge after its handshake. A read raises rsp_valid one edge after it is presented to the idle block. The response and the command complete together on the first edge that sees rsp_ready high. cmd_ready is combinational, so it matches the current inputs within the same cycle. The bench keeps a behavioural model that it advances on every rising edge, using only the inputs. It compares every output with that model at the falling edge, before new stimulus is driven, so each result is checked in exactly the cycle it is due.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_WAIT = 1'b1
    } ctl_state_t;

    localparam int DEF_ADDR_W = 2;
    localparam int DEF_DATA_W = 2;
    localparam int DEF_RSP_W  = 4;

    function automatic int cmd_width(input int addr_w, input int data_w);
        return 1 + addr_w + data_w;
    endfunction

endpackage

// File: rtl/cmdreg_ctrl.sv
module cmdreg_ctrl
    import cmdreg_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int CMD_W = 1 + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              rsp_ready,
    output logic              cmd_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_load,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_done
);

    ctl_state_t state_q, state_d;
    logic       is_read;

    assign is_read = cmd_word[CMD_W-1];
    assign wr_addr = cmd_word[DATA_W +: ADDR_W];
    assign rd_addr = cmd_word[DATA_W +: ADDR_W];
    assign wr_data = cmd_word[DATA_W-1:0];

    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        wr_en     = 1'b0;
        rd_load   = 1'b0;
        rsp_done  = 1'b0;
        unique case (state_q)
            CTL_IDLE: begin
                cmd_ready = !is_read;
                wr_en     = cmd_valid && !is_read;
                rd_load   = cmd_valid && is_read;
                if (rd_load) state_d = CTL_WAIT;
            end
            CTL_WAIT: begin
                cmd_ready = rsp_ready;
                rsp_done  = rsp_ready;
                if (rsp_ready) state_d = CTL_IDLE;
            end
            default: state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CTL_IDLE;
        else     state_q <= state_d;
    end

    // only one of the write and read-start strobes may fire in a cycle
    assert_single_op_R1: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_load));

    // a new read never starts while one is pending
    assert_one_inflight_R5: assert property (@(posedge clk) disable iff (rst)
        rd_load |=> !rd_load);

endmodule

// File: rtl/cmdreg_store.sv
module cmdreg_store #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 2,
    localparam int NREG  = 1 << ADDR_W,
    localparam int OBS_W = NREG * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [OBS_W-1:0]  obs
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                regs[g] <= wr_data;
        end
        assign obs[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rd_data = regs[rd_addr];

    // storage only moves on a write strobe
    assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(obs));

    // the written field carries the written data afterwards
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (obs[wr_addr_q*DATA_W +: DATA_W] == wr_data_q));

    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;
    always_ff @(posedge clk) begin
        wr_addr_q <= wr_addr;
        wr_data_q <= wr_data;
    end

endmodule

// File: rtl/cmdreg_resp.sv
module cmdreg_resp #(
    parameter int DATA_W = 2,
    parameter int RSP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rsp_done,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [RSP_W-1:0]  rsp_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else if (rd_load) begin
            rsp_valid <= 1'b1;
            rsp_data  <= RSP_W'(rd_data);
        end else if (rsp_done) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end
    end

    assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_data == '0));

endmodule

// File: rtl/cmdreg_file.sv
module cmdreg_file
    import cmdreg_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int RSP_W  = DEF_RSP_W,
    localparam int CMD_W = 1 + ADDR_W + DATA_W,
    localparam int OBS_W = (1 << ADDR_W) * DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [RSP_W-1:0] rsp_data,
    output logic [OBS_W-1:0] obs
);

    logic              wr_en, rd_load, rsp_done;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    cmdreg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .rsp_ready(rsp_ready), .cmd_ready(cmd_ready), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_load(rd_load),
        .rd_addr(rd_addr), .rsp_done(rsp_done)
    );

    cmdreg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .obs(obs)
    );

    cmdreg_resp #(.DATA_W(DATA_W), .RSP_W(RSP_W)) u_resp (
        .clk(clk), .rst(rst), .rd_load(rd_load), .rd_data(rd_data),
        .rsp_done(rsp_done), .rsp_ready(rsp_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // a read handshake only happens together with the response handshake
    assert_read_ack_late_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_word[CMD_W-1]) |-> (rsp_valid && rsp_ready));

    // an accepted write never produces a response
    assert_write_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !cmd_word[CMD_W-1]) |=> !rsp_valid);

    // a response is always preceded by a read being presented
    assert_rsp_from_read_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(cmd_valid && cmd_word[CMD_W-1]));

    // with no command offered, no response starts
    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && !rsp_valid) |=> !rsp_valid);

endmodule

// File: tb/cmdreg_file_bench.sv
module cmdreg_file_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [4:0] cmd_word = '0;
    logic       rsp_ready = 1'b0;
    logic       cmd_ready, rsp_valid;
    logic [3:0] rsp_data;
    logic [7:0] obs;

    int vectors = 0;
    int fails   = 0;
    bit started = 0;
    bit done    = 0;

    // behavioural reference
    int mreg [4];
    bit mbusy;
    int mrsp;

    always #(CLK_P/2) clk = ~clk;

    cmdreg_file u_cmdreg_file (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .obs(obs)
    );

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            foreach (mreg[i]) mreg[i] = 0;
            mbusy = 0;
            mrsp  = 0;
        end else if (!mbusy) begin
            if (cmd_valid && !cmd_word[4])
                mreg[cmd_word[3:2]] = int'(cmd_word[1:0]);
            else if (cmd_valid && cmd_word[4]) begin
                mbusy = 1;
                mrsp  = mreg[cmd_word[3:2]];
            end
        end else if (rsp_ready) begin
            mbusy = 0;
            mrsp  = 0;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int eobs;
            int erdy;
            eobs = 0;
            for (int i = 0; i < 4; i++) eobs |= (mreg[i] & 3) << (2*i);
            erdy = mbusy ? int'(rsp_ready) : int'(!cmd_word[4]);
            check("R2/R7/R8/R10", "obs", int'(obs), eobs);
            check("R3/R5", "cmd_ready", int'(cmd_ready), erdy);
            check("R4/R5/R8", "rsp_valid", int'(rsp_valid), int'(mbusy));
            check("R4/R6/R9", "rsp_data", int'(rsp_data), mrsp);
        end
    end

    task automatic drive(input bit v, input logic [4:0] w, input bit rr);
        @(negedge clk);
        #1;
        cmd_valid = v;
        cmd_word  = w;
        rsp_ready = rr;
    endtask

    // R1: bit4 mode, bits 3:2 address, bits 1:0 data
    task automatic wr(input int a, input int d);
        drive(1, {1'b0, 2'(a), 2'(d)}, 0);
    endtask

    task automatic rd(input int a, input int junk, input int stall);
        drive(1, {1'b1, 2'(a), 2'(junk)}, stall == 0);
        for (int i = 0; i < stall; i++) drive(1, {1'b1, 2'(a), 2'(junk)}, 0);
        drive(1, {1'b1, 2'(a), 2'(junk)}, 1);
    endtask

    initial begin
        #(CLK_P*4000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R3 R2: first write, address 0 value 3
        wr(0, 3);
        drive(0, 5'b0, 0);
        // R4 R5 R6 R7: read address 0 with back-pressure
        rd(0, 0, 3);
        drive(0, 5'b0, 0);
        // R2: fill every register, back to back
        wr(1, 2); wr(2, 1); wr(3, 3); wr(0, 1);
        // R7: reads with nonzero data bits, no stall and stalled
        rd(3, 0, 0);
        rd(1, 3, 2);
        rd(2, 2, 0);
        rd(0, 1, 1);
        // R10: idle words with read and write patterns but valid low
        drive(0, 5'b10111, 0);
        drive(0, 5'b01110, 1);
        drive(0, 5'b00000, 0);
        // write directly after a read
        rd(3, 0, 0);
        wr(3, 0);
        rd(3, 2, 1);
        // R8: reset in the middle of a pending read
        drive(1, 5'b10100, 0);
        drive(1, 5'b10100, 0);
        #1 rst = 1;
        drive(0, 5'b0, 0);
        #1 rst = 1;
        drive(0, 5'b0, 0);
        #1 rst = 0;
        rd(1, 0, 0);
        wr(2, 2);
        rd(2, 0, 2);
        repeat (3) drive(0, 5'b0, 0);
        @(negedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule